// File: doc/BRIEF.md
# Latched Alarm Status Register Bank

This block holds the sticky status bits of one framer status register for a T3/E3 line interface. It has two kinds of source. Two are level conditions from alarm detectors: remote alarm and idle signal. Two are one-cycle pulses from the framer: transmit and receive start of frame. Each source latches into its own status bit. A CPU sees the bits through a simple read port, which has a read strobe and a register select. A read of this register clears the bits by their kind. A condition bit survives a read while its detector still reports the condition. A pulse bit always clears on a read.

Every bit also keeps its own interrupt-pending flag. A condition bit raises its flag when the detector output changes, whether it rises or falls. A pulse bit raises its flag only when the pulse sets it. A read of the register releases the pending flags. The interrupt output is active high. It asserts when a pending flag has its per-bit mask set and the register's master mask is also set. When the line runs in E3 mode, the idle bit has no meaning. In that mode the idle bit is held clear and cannot interrupt.

All source inputs are synchronous to the register clock. A change of state is found by comparing each condition input with a registered copy of the same input.

Top module: `frm_alarm_stat`

## Requirements
- R1: A condition bit reads one after any clock edge at which its detector input was high. Remote alarm is rd_data bit 3 and idle is rd_data bit 4.
- R2: A read clears a condition bit at that edge only if its detector input is low in the read cycle. If the input is high, the bit stays one.
- R3: A condition detector that changes level, rising or falling, makes that bit's interrupt pending at the next edge.
- R4: irq is high only when master_mask is one and some pending bit has its own int_mask bit set. The int_mask order is [0] remote alarm, [1] idle, [2] transmit frame, [3] receive frame.
- R5: A read releases every pending flag at that edge unless a new cause for that bit arrives in the same cycle.
- R6: A pulse bit is set by each pulse and is cleared by a read regardless of level. Transmit frame is rd_data bit 5 and receive frame is rd_data bit 6. A pulse that arrives in the same cycle as a read leaves the bit set.
- R7: A pulse bit becomes pending only when a pulse sets it. Its clearing, or the pulse going low, raises no interrupt.
- R8: While e3_mode is one, the idle bit and its pending flag are held at zero, whatever idle_det does.
- R9: rd_data shows the status bits only when rd_sel equals SEL_ADDR and is all zero otherwise. A strobe with another select clears nothing. A read returns the values from before the clear.
- R10: After reset every status bit and pending flag is zero, so rd_data is zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| e3_mode | input | 1 | One selects E3 line mode, which disables the idle bit |
| rai_det | input | 1 | Remote alarm detector level |
| idle_det | input | 1 | Idle signal detector level |
| tsof_pulse | input | 1 | One-cycle transmit frame boundary pulse |
| rsof_pulse | input | 1 | One-cycle receive frame boundary pulse |
| rd_stb | input | 1 | Single-cycle read strobe |
| rd_sel | input | SEL_W | Register select for the read |
| rd_data | output | DATA_W | Latched status image |
| int_mask | input | 4 | Per-bit interrupt enables |
| master_mask | input | 1 | Register-level interrupt enable |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench reads a condition bit while its detector is still high. A design that clears the bit anyway would lose an alarm that is still present. The bench then lets the detector fall without a read. The bit must stay set and raise a new interrupt, so a design that forgot falling edges would stay silent. The bench also sends a frame pulse in the same cycle as a read. Here a design that gave the read priority would drop a frame event. Other tests switch to E3 mode while idle is asserted, strobe with the wrong select, and clear each of the two mask levels in turn. Errors in these tests show up as a stray idle bit, bits cleared by the wrong read, or an interrupt that escapes its mask.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;

    localparam int SRC_N     = 4;
    localparam int SRC_RAI   = 0;
    localparam int SRC_IDLE  = 1;
    localparam int SRC_TSOF  = 2;
    localparam int SRC_RSOF  = 3;
    localparam int FIELD_LSB = 3;

    typedef enum logic {
        KIND_COND  = 1'b0,
        KIND_PULSE = 1'b1
    } src_kind_e;

    typedef struct packed {
        logic sticky;
        logic pend;
    } cell_state_t;

    function automatic src_kind_e kind_of(input int idx);
        return (idx == SRC_TSOF || idx == SRC_RSOF) ? KIND_PULSE : KIND_COND;
    endfunction

endpackage

// File: rtl/stat_bit_cell.sv
import stat_bank_pkg::*;

module stat_bit_cell #(
    parameter src_kind_e KIND = KIND_COND
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic kill,
    input  logic rd_hit,
    output logic status,
    output logic pending
);

    cell_state_t st_q, st_d;
    logic        src_eff;
    logic        change;

    assign src_eff = src & ~kill;

    generate
        if (KIND == KIND_COND) begin : g_cond
            logic seen_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) seen_q <= 1'b0;
                else        seen_q <= src_eff;
            end

            assign change = src_eff ^ seen_q;

            AST_COND_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
                (src && !kill) |=> status);                                    // R1
            AST_COND_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_hit && !src && !kill) |=> !status);                        // R2
            AST_COND_COS: assert property (@(posedge clk) disable iff (!rst_n)
                (!kill && (src != seen_q)) |=> pending);                       // R3
            AST_COND_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_hit && !kill && (src == seen_q)) |=> !pending);            // R5
        end else begin : g_pulse
            assign change = src_eff;

            AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
                (src && !kill) |=> (status && pending));                       // R6
            AST_EVT_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_hit && !src) |=> (!status && !pending));                   // R6
            AST_EVT_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
                (!src || kill) |=> !$rose(pending));                           // R7
        end
    endgenerate

    always_comb begin
        st_d        = st_q;
        st_d.sticky = src_eff | (st_q.sticky & ~rd_hit);
        st_d.pend   = change  | (st_q.pend   & ~rd_hit);
        if (kill) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status  = st_q.sticky;
    assign pending = st_q.pend;

    AST_KILL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (!status && !pending));                                       // R8

endmodule

// File: rtl/stat_irq_merge.sv
module stat_irq_merge #(
    parameter int N = 4
) (
    input  logic [N-1:0] pend,
    input  logic [N-1:0] mask,
    input  logic         master,
    output logic         irq
);

    logic [N-1:0] armed;

    always_comb begin
        armed = pend & mask;
        irq   = master & (|armed);
    end

endmodule

// File: rtl/frm_alarm_stat.sv
import stat_bank_pkg::*;

module frm_alarm_stat #(
    parameter int                DATA_W   = 8,
    parameter int                SEL_W    = 4,
    parameter logic [SEL_W-1:0]  SEL_ADDR = 'h2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              e3_mode,
    input  logic              rai_det,
    input  logic              idle_det,
    input  logic              tsof_pulse,
    input  logic              rsof_pulse,
    input  logic              rd_stb,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic [SRC_N-1:0]  int_mask,
    input  logic              master_mask,
    output logic              irq
);

    localparam int FIELD_MSB = FIELD_LSB + SRC_N - 1;

    logic              sel_hit;
    logic              rd_hit;
    logic [SRC_N-1:0]  src_vec;
    logic [SRC_N-1:0]  kill_vec;
    logic [SRC_N-1:0]  status_vec;
    logic [SRC_N-1:0]  pend_vec;

    assign sel_hit = (rd_sel == SEL_ADDR);
    assign rd_hit  = rd_stb & sel_hit;

    always_comb begin
        src_vec            = '0;
        src_vec[SRC_RAI]   = rai_det;
        src_vec[SRC_IDLE]  = idle_det;
        src_vec[SRC_TSOF]  = tsof_pulse;
        src_vec[SRC_RSOF]  = rsof_pulse;
        kill_vec           = '0;
        kill_vec[SRC_IDLE] = e3_mode;
    end

    generate
        for (genvar i = 0; i < SRC_N; i++) begin : g_bit
            stat_bit_cell #(
                .KIND (kind_of(i))
            ) u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .src     (src_vec[i]),
                .kill    (kill_vec[i]),
                .rd_hit  (rd_hit),
                .status  (status_vec[i]),
                .pending (pend_vec[i])
            );
        end
    endgenerate

    stat_irq_merge #(
        .N (SRC_N)
    ) u_merge (
        .pend   (pend_vec),
        .mask   (int_mask),
        .master (master_mask),
        .irq    (irq)
    );

    always_comb begin
        rd_data = '0;
        if (sel_hit) begin
            rd_data[FIELD_MSB:FIELD_LSB] = status_vec;
        end
    end

    AST_IRQ_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mask |-> !irq);                                                // R4
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_vec & int_mask) == '0) |-> !irq);                               // R4
    AST_RD_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_hit |-> (rd_data == '0));                                         // R9
    AST_RD_OTHER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !sel_hit && rai_det) |=> status_vec[SRC_RAI]);              // R9

endmodule

// File: tb/sim_frm_alarm_stat.sv
`timescale 1ns/1ps

module sim_frm_alarm_stat;

    localparam int         DW   = 8;
    localparam int         SW   = 4;
    localparam logic [3:0] ADDR = 4'h2;
    localparam logic [3:0] OTHR = 4'h5;
    localparam int         NV   = 22;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          e3_mode, rai_det, idle_det, tsof_pulse, rsof_pulse;
    logic          rd_stb;
    logic [SW-1:0] rd_sel;
    logic [DW-1:0] rd_data;
    logic [3:0]    int_mask;
    logic          master_mask;
    logic          irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    frm_alarm_stat #(.DATA_W(DW), .SEL_W(SW), .SEL_ADDR(ADDR)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .e3_mode     (e3_mode),
        .rai_det     (rai_det),
        .idle_det    (idle_det),
        .tsof_pulse  (tsof_pulse),
        .rsof_pulse  (rsof_pulse),
        .rd_stb      (rd_stb),
        .rd_sel      (rd_sel),
        .rd_data     (rd_data),
        .int_mask    (int_mask),
        .master_mask (master_mask),
        .irq         (irq)
    );

    // {req, e3 rai idle tsof rsof, rd, mask, master, expected data, expected irq}
    // Expected values are sampled before the edge that applies the vector.
    localparam logic [23:0] VEC [NV] = '{
        {4'd10, 5'b00000, 1'b0, 4'hF, 1'b1, 8'h00, 1'b0},  // R10 idle start
        {4'd1,  5'b01000, 1'b0, 4'hF, 1'b1, 8'h00, 1'b0},  // R1 raise remote alarm
        {4'd1,  5'b01000, 1'b1, 4'hF, 1'b1, 8'h08, 1'b1},  // R1 latched, read while high
        {4'd2,  5'b01000, 1'b0, 4'hF, 1'b1, 8'h08, 1'b0},  // R2 survives read, R5 released
        {4'd2,  5'b00000, 1'b0, 4'hF, 1'b1, 8'h08, 1'b0},  // R2 detector falls
        {4'd3,  5'b00000, 1'b1, 4'hF, 1'b1, 8'h08, 1'b1},  // R3 falling edge pending
        {4'd2,  5'b00000, 1'b0, 4'hF, 1'b1, 8'h00, 1'b0},  // R2 cleared once gone
        {4'd6,  5'b00010, 1'b0, 4'hF, 1'b1, 8'h00, 1'b0},  // R6 transmit frame pulse
        {4'd4,  5'b00000, 1'b0, 4'hB, 1'b1, 8'h20, 1'b0},  // R4 own mask off
        {4'd4,  5'b00000, 1'b0, 4'hF, 1'b0, 8'h20, 1'b0},  // R4 master off
        {4'd4,  5'b00000, 1'b0, 4'hF, 1'b1, 8'h20, 1'b1},  // R4 both on
        {4'd6,  5'b00000, 1'b1, 4'hF, 1'b1, 8'h20, 1'b1},  // R6 read clears pulse bit
        {4'd7,  5'b00000, 1'b0, 4'hF, 1'b1, 8'h00, 1'b0},  // R7 no interrupt on clear
        {4'd6,  5'b00001, 1'b1, 4'hF, 1'b1, 8'h00, 1'b0},  // R6 pulse and read together
        {4'd6,  5'b00000, 1'b0, 4'hF, 1'b1, 8'h40, 1'b1},  // R6 receive bit kept
        {4'd5,  5'b00000, 1'b1, 4'hF, 1'b1, 8'h40, 1'b1},  // R5 read releases
        {4'd1,  5'b00100, 1'b0, 4'hF, 1'b1, 8'h00, 1'b0},  // R1 idle rises
        {4'd2,  5'b00100, 1'b1, 4'hF, 1'b1, 8'h10, 1'b1},  // R2 idle read while high
        {4'd8,  5'b10100, 1'b0, 4'hF, 1'b1, 8'h10, 1'b0},  // R8 enter E3
        {4'd8,  5'b10100, 1'b0, 4'hF, 1'b1, 8'h00, 1'b0},  // R8 idle held clear
        {4'd8,  5'b00000, 1'b0, 4'hF, 1'b1, 8'h00, 1'b0},  // R8 leave E3
        {4'd8,  5'b00000, 1'b0, 4'hF, 1'b1, 8'h00, 1'b0}   // R8 stays clear
    };

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic drive_idle();
        e3_mode = 1'b0; rai_det = 1'b0; idle_det = 1'b0;
        tsof_pulse = 1'b0; rsof_pulse = 1'b0;
        rd_stb = 1'b0; rd_sel = ADDR;
        int_mask = 4'hF; master_mask = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        drive_idle();
        rst_n = 1'b0;
        rai_det = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 data in reset", int'(rd_data), 0);
        check("R10 irq in reset", int'(irq), 0);
        rai_det = 1'b0;
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [3:0] req;
            logic [7:0] exp_d;
            logic       exp_q;
            @(negedge clk);
            {req, e3_mode, rai_det, idle_det, tsof_pulse, rsof_pulse,
             rd_stb, int_mask, master_mask, exp_d, exp_q} = VEC[i];
            #1;
            check($sformatf("R%0d vec %0d data", req, i), int'(rd_data), int'(exp_d));
            check($sformatf("R%0d vec %0d irq", req, i), int'(irq), int'(exp_q));
        end

        // R9: strobe with a foreign select reads zero and clears nothing
        @(negedge clk); drive_idle(); rai_det = 1'b1;
        @(negedge clk); rai_det = 1'b0;
        @(negedge clk); rd_stb = 1'b1; rd_sel = OTHR;
        #1; check("R9 foreign select reads zero", int'(rd_data), 0);
        @(negedge clk); rd_stb = 1'b0; rd_sel = ADDR;
        #1; check("R9 bit kept after foreign strobe", int'(rd_data), 8'h08);
        check("R9 irq kept after foreign strobe", int'(irq), 1);
        @(negedge clk); rd_stb = 1'b1;
        #1; check("R9 read returns pre-clear value", int'(rd_data), 8'h08);
        @(negedge clk); rd_stb = 1'b0;
        #1; check("R5 cleared by real read", int'(rd_data), 0);
        check("R5 irq released", int'(irq), 0);

        // R4: per-bit mask ordering with both conditions pending
        @(negedge clk); rai_det = 1'b1; idle_det = 1'b1;
        @(negedge clk); int_mask = 4'b0001;
        #1; check("R1 both condition bits", int'(rd_data), 8'h18);
        check("R4 remote alarm mask alone", int'(irq), 1);
        @(negedge clk); int_mask = 4'b1100;
        #1; check("R4 condition masks off", int'(irq), 0);
        @(negedge clk); rai_det = 1'b0; idle_det = 1'b0; int_mask = 4'b0010;
        #1; check("R4 idle mask alone", int'(irq), 1);
        @(negedge clk); rd_stb = 1'b1; int_mask = 4'hF;
        #1; check("R3 still set before read", int'(rd_data), 8'h18);
        @(negedge clk); rd_stb = 1'b0;
        #1; check("R2 both cleared after fall", int'(rd_data), 0);
        check("R5 irq low at end", int'(irq), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule